// File: doc/BRIEF.md
# Cascaded Timebase Prescaler

This block turns the system clock into the time bases that the rest of a controller uses. A microsecond divider counts system clocks. A millisecond divider counts microsecond ticks. A hundred-millisecond divider counts millisecond ticks, and a seconds divider counts those in turn. Two flash timing dividers sit beside this chain: one paces writes in microseconds and one paces erases in milliseconds. A separate analog branch divides the system clock by a programmable value and then by a fixed 64 to make the modulator clock enable. A timer prescaler gives a count enable every 12 system clocks, or every 4 in its fast mode.

Every divide value is a plain input that a register elsewhere drives. Each divider loads its divide value only at its terminal count, so a new value never shortens the period that is already running. All outputs are single-cycle enable pulses. They are not clocks, so downstream logic stays in the one clock domain. The millisecond and seconds ticks each also set a sticky interrupt flag. The flag holds until software pulses its clear input, and a separate enable gates the flag onto the interrupt line.

The block moves no data stream, so it has no valid/ready interface and no back-pressure. Every pin is a plain control or status signal.

Top module: `timing_chain`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, every tick output, both flags and both interrupt lines are 0.
- R2: `us_tick` is a one-cycle pulse that repeats every `usec_div`+1 system clocks.
- R3: `ms_tick` repeats every `msec_div`+1 microsecond ticks. `hms_tick` repeats every `hms_div`+1 millisecond ticks. `sec_tick` repeats every `sec_div`+1 hundred-millisecond ticks.
- R4: A divide value takes effect only at the divider's next terminal count. The period that is running when the value changes keeps the old length, and the period after it uses the new value.
- R5: `mod_ce` pulses once every (`aclk_div`+1)×64 system clocks.
- R6: While `pdown` is high, `mod_ce` stays 0 from the next clock onward, and the microsecond chain keeps its normal period.
- R7: `flw_tick` repeats every 30+min(`fwr_sel`,10) microsecond ticks, which covers 30 to 40 µs.
- R8: `fle_tick` repeats every 5+min(`fer_sel`,6) millisecond ticks, which covers 5 to 11 ms.
- R9: `tmr_tick` pulses every 12 system clocks when `tmr_fast` is 0, and every 4 system clocks when `tmr_fast` is 1.
- R10: A tick sets its flag on the next clock. The flag stays set until a clear strobe. If a set and a clear arrive in the same cycle, the flag is set.
- R11: Each interrupt line is its flag ANDed with its enable. Bit 0 of the enable and clear vectors is the millisecond source, and bit 1 is the seconds source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usec_div | input | 8 | Microsecond divide value minus one |
| msec_div | input | 16 | Millisecond divide value minus one |
| hms_div | input | 8 | Hundred-millisecond divide value minus one |
| sec_div | input | 4 | Seconds divide value minus one |
| aclk_div | input | 8 | Analog pre-divide value minus one |
| pdown | input | 1 | Stops the analog branch |
| fwr_sel | input | 4 | Flash write interval select |
| fer_sel | input | 4 | Flash erase interval select |
| tmr_fast | input | 1 | 1 = count every 4 clocks, 0 = every 12 |
| irq_en | input | 2 | Interrupt enables: bit 0 millisecond, bit 1 seconds |
| irq_clr | input | 2 | Clear strobes, same bit order as `irq_en` |
| us_tick | output | 1 | Microsecond pulse |
| ms_tick | output | 1 | Millisecond pulse |
| hms_tick | output | 1 | Hundred-millisecond pulse |
| sec_tick | output | 1 | Seconds pulse |
| mod_ce | output | 1 | Modulator clock enable |
| flw_tick | output | 1 | Flash write time base |
| fle_tick | output | 1 | Flash erase time base |
| tmr_tick | output | 1 | Timer count enable |
| irq_flag | output | 2 | Sticky flags: bit 0 millisecond, bit 1 seconds |
| irq | output | 2 | Masked interrupt lines |

## Verification
Some rules can be checked on every cycle, and the assertions do that. A divider never raises its tick twice in a row when its divide value is nonzero. A tick only follows a cycle in which its divider was enabled. Power-down silences the modulator enable on the next clock. A flag follows its set and clear strobes, with set winning. Other behaviour needs a whole scenario to show: the period of each stage, the cascade multiplying those periods, the clamping of the flash selects, the timer rate switch, and the deferred reload. The bench covers these by measuring the spacing between pulses after the configuration has settled.

// File: rtl/tmchain_pkg.sv
package tmchain_pkg;
  localparam int MOD_PRESCALE = 64;
  localparam int FLW_BASE     = 30;
  localparam int FLW_SPAN     = 10;
  localparam int FLE_BASE     = 5;
  localparam int FLE_SPAN     = 6;
  localparam int TMR_SLOW     = 12;
  localparam int TMR_FAST     = 4;
  localparam int NIRQ         = 2;

  typedef enum logic {
    RATE_SLOW = 1'b0,
    RATE_FAST = 1'b1
  } tmr_rate_e;
endpackage

// File: rtl/tc_divider.sv
module tc_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         armed_q;

  // Down-counter; the divide value is sampled only at reload.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      tick_o  <= 1'b0;
    end else if (!armed_q) begin
      cnt_q   <= div_i;
      armed_q <= 1'b1;
      tick_o  <= 1'b0;
    end else if (en_i) begin
      if (cnt_q == '0) begin
        cnt_q  <= div_i;
        tick_o <= 1'b1;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
        tick_o <= 1'b0;
      end
    end else begin
      tick_o <= 1'b0;
    end
  end

  AST_TICK_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && ($past(div_i) != '0)) |=> !tick_o) else $error("tick wider than one cycle"); // R2
  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(en_i)) else $error("tick without enable"); // R2
endmodule

// File: rtl/tc_irq_flag.sv
module tc_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= set_i | (flag_o & ~clr_i);
  end

  assign irq_o = flag_o & ie_i;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o) else $error("flag missed a set"); // R10
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o) else $error("flag survived a clear"); // R10
endmodule

// File: rtl/timing_chain.sv
module timing_chain
  import tmchain_pkg::*;
#(
  parameter int USW = 8,
  parameter int MSW = 16,
  parameter int HMW = 8,
  parameter int SCW = 4,
  parameter int ACW = 8,
  parameter int FSW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [USW-1:0]  usec_div,
  input  logic [MSW-1:0]  msec_div,
  input  logic [HMW-1:0]  hms_div,
  input  logic [SCW-1:0]  sec_div,
  input  logic [ACW-1:0]  aclk_div,
  input  logic            pdown,
  input  logic [FSW-1:0]  fwr_sel,
  input  logic [FSW-1:0]  fer_sel,
  input  logic            tmr_fast,
  input  logic [NIRQ-1:0] irq_en,
  input  logic [NIRQ-1:0] irq_clr,
  output logic            us_tick,
  output logic            ms_tick,
  output logic            hms_tick,
  output logic            sec_tick,
  output logic            mod_ce,
  output logic            flw_tick,
  output logic            fle_tick,
  output logic            tmr_tick,
  output logic [NIRQ-1:0] irq_flag,
  output logic [NIRQ-1:0] irq
);
  localparam int MODW = $clog2(MOD_PRESCALE);
  localparam int FLWW = $clog2(FLW_BASE + FLW_SPAN);
  localparam int FLEW = $clog2(FLE_BASE + FLE_SPAN);
  localparam int TMRW = $clog2(TMR_SLOW);

  // Main chain: each stage is enabled by the previous stage's tick.
  tc_divider #(.W(USW)) u_us  (.clk(clk), .rst_n(rst_n), .en_i(1'b1),
                               .div_i(usec_div), .tick_o(us_tick));
  tc_divider #(.W(MSW)) u_ms  (.clk(clk), .rst_n(rst_n), .en_i(us_tick),
                               .div_i(msec_div), .tick_o(ms_tick));
  tc_divider #(.W(HMW)) u_hms (.clk(clk), .rst_n(rst_n), .en_i(ms_tick),
                               .div_i(hms_div), .tick_o(hms_tick));
  tc_divider #(.W(SCW)) u_sec (.clk(clk), .rst_n(rst_n), .en_i(hms_tick),
                               .div_i(sec_div), .tick_o(sec_tick));

  // Analog branch: programmable pre-divide, then a fixed divide by 64.
  logic aclk_tick;
  tc_divider #(.W(ACW)) u_aclk (.clk(clk), .rst_n(rst_n), .en_i(~pdown),
                                .div_i(aclk_div), .tick_o(aclk_tick));
  tc_divider #(.W(MODW)) u_mod (.clk(clk), .rst_n(rst_n), .en_i(aclk_tick & ~pdown),
                                .div_i(MODW'(MOD_PRESCALE - 1)), .tick_o(mod_ce));

  // Flash time bases with clamped select fields.
  logic [FSW-1:0]  fwr_c, fer_c;
  logic [FLWW-1:0] flw_div;
  logic [FLEW-1:0] fle_div;
  always_comb begin
    fwr_c   = (int'(fwr_sel) > FLW_SPAN) ? FSW'(FLW_SPAN) : fwr_sel;
    fer_c   = (int'(fer_sel) > FLE_SPAN) ? FSW'(FLE_SPAN) : fer_sel;
    flw_div = FLWW'(FLW_BASE - 1) + FLWW'(fwr_c);
    fle_div = FLEW'(FLE_BASE - 1) + FLEW'(fer_c);
  end
  tc_divider #(.W(FLWW)) u_flw (.clk(clk), .rst_n(rst_n), .en_i(us_tick),
                                .div_i(flw_div), .tick_o(flw_tick));
  tc_divider #(.W(FLEW)) u_fle (.clk(clk), .rst_n(rst_n), .en_i(ms_tick),
                                .div_i(fle_div), .tick_o(fle_tick));

  // Timer prescale: 12 or 4 system clocks per count.
  tmr_rate_e       rate;
  logic [TMRW-1:0] tmr_div;
  always_comb begin
    rate = tmr_rate_e'(tmr_fast);
    case (rate)
      RATE_FAST: tmr_div = TMRW'(TMR_FAST - 1);
      default:   tmr_div = TMRW'(TMR_SLOW - 1);
    endcase
  end
  tc_divider #(.W(TMRW)) u_tmr (.clk(clk), .rst_n(rst_n), .en_i(1'b1),
                                .div_i(tmr_div), .tick_o(tmr_tick));

  // Interrupt flags: bit 0 millisecond, bit 1 seconds.
  logic [NIRQ-1:0] irq_src;
  assign irq_src = {sec_tick, ms_tick};
  for (genvar g = 0; g < NIRQ; g++) begin : g_irq
    tc_irq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(irq_src[g]), .clr_i(irq_clr[g]),
      .ie_i(irq_en[g]), .flag_o(irq_flag[g]), .irq_o(irq[g])
    );
  end

  AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pdown |=> !mod_ce) else $error("modulator enable during power-down"); // R6
  AST_MS_NEEDS_US: assert property (@(posedge clk) disable iff (!rst_n)
    ms_tick |-> $past(us_tick)) else $error("ms tick without us tick"); // R3
endmodule

// File: tb/sim_timing_chain.sv
module sim_timing_chain;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  usec_div = 8'd3;
  logic [15:0] msec_div = 16'd4;
  logic [7:0]  hms_div  = 8'd2;
  logic [3:0]  sec_div  = 4'd1;
  logic [7:0]  aclk_div = 8'd0;
  logic        pdown    = 1'b0;
  logic [3:0]  fwr_sel  = 4'd0;
  logic [3:0]  fer_sel  = 4'd0;
  logic        tmr_fast = 1'b0;
  logic [1:0]  irq_en   = 2'b00;
  logic [1:0]  irq_clr  = 2'b00;
  logic us_tick, ms_tick, hms_tick, sec_tick, mod_ce, flw_tick, fle_tick, tmr_tick;
  logic [1:0] irq_flag, irq;

  timing_chain u0 (
    .clk(clk), .rst_n(rst_n), .usec_div(usec_div), .msec_div(msec_div),
    .hms_div(hms_div), .sec_div(sec_div), .aclk_div(aclk_div), .pdown(pdown),
    .fwr_sel(fwr_sel), .fer_sel(fer_sel), .tmr_fast(tmr_fast), .irq_en(irq_en),
    .irq_clr(irq_clr), .us_tick(us_tick), .ms_tick(ms_tick), .hms_tick(hms_tick),
    .sec_tick(sec_tick), .mod_ce(mod_ce), .flw_tick(flw_tick), .fle_tick(fle_tick),
    .tmr_tick(tmr_tick), .irq_flag(irq_flag), .irq(irq)
  );

  int total = 0;
  int bad = 0;

  // columns: usec_div, msec_div, aclk_div, tmr_fast, fwr_sel, fer_sel
  localparam int NV = 4;
  localparam int VEC [0:NV-1][0:5] = '{
    '{3, 4, 0, 0, 0, 0},
    '{1, 2, 2, 1, 15, 9},
    '{0, 9, 1, 0, 5, 3},
    '{2, 1, 0, 1, 10, 6}
  };

  function automatic logic pick(int k);
    case (k)
      0: return us_tick;
      1: return ms_tick;
      2: return hms_tick;
      3: return sec_tick;
      4: return mod_ce;
      5: return flw_tick;
      6: return fle_tick;
      default: return tmr_tick;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(int k);
    @(negedge clk);
    while (!pick(k)) @(negedge clk);
  endtask

  task automatic measure(int k, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pick(k));
  endtask

  task automatic settled_period(int k, output int n);
    wait_tick(k);
    wait_tick(k);
    measure(k, n);
  endtask

  function automatic int mn(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int n, hits;
    // R1: outputs quiet during reset and on the first cycle after release
    repeat (3) @(negedge clk);
    chk("R1 in reset", int'({us_tick, ms_tick, hms_tick, sec_tick, mod_ce, flw_tick,
                             fle_tick, tmr_tick, irq_flag, irq}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'({us_tick, ms_tick, hms_tick, sec_tick, mod_ce, flw_tick,
                                  fle_tick, tmr_tick, irq_flag, irq}), 0);

    // Table walk: periods of each stage for several configurations
    for (int v = 0; v < NV; v++) begin
      int u, m, a;
      u = VEC[v][0]; m = VEC[v][1]; a = VEC[v][2];
      usec_div = 8'(u); msec_div = 16'(m); aclk_div = 8'(a);
      tmr_fast = VEC[v][3] != 0;
      fwr_sel = 4'(VEC[v][4]); fer_sel = 4'(VEC[v][5]);
      settled_period(0, n); chk("R2 us period", n, u + 1);
      settled_period(1, n); chk("R3 ms period", n, (m + 1) * (u + 1));
      settled_period(4, n); chk("R5 mod period", n, (a + 1) * 64);
      settled_period(7, n); chk("R9 timer period", n, (VEC[v][3] != 0) ? 4 : 12);
      settled_period(5, n); chk("R7 flash write period", n, (30 + mn(VEC[v][4], 10)) * (u + 1));
      settled_period(6, n); chk("R8 flash erase period", n,
                                (5 + mn(VEC[v][5], 6)) * (m + 1) * (u + 1));
    end

    // R3: hundred-ms and seconds stages
    usec_div = 8'd1; msec_div = 16'd1; hms_div = 8'd2; sec_div = 4'd1;
    settled_period(2, n); chk("R3 hms period", n, 12);
    settled_period(3, n); chk("R3 sec period", n, 24);

    // R2: pulse one cycle wide
    usec_div = 8'd3;
    wait_tick(0); wait_tick(0);
    @(negedge clk);
    chk("R2 one cycle wide", int'(us_tick), 0);

    // R4: reload deferred to terminal count
    usec_div = 8'd5;
    wait_tick(0); wait_tick(0);
    usec_div = 8'd1;
    measure(0, n); chk("R4 running period kept", n, 6);
    measure(0, n); chk("R4 new period applied", n, 2);

    // R6: power-down stops mod_ce, chain unaffected
    aclk_div = 8'd0; usec_div = 8'd2;
    wait_tick(4);
    pdown = 1'b1;
    hits = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (mod_ce) hits++;
    end
    chk("R6 mod_ce quiet in power-down", hits, 0);
    settled_period(0, n); chk("R6 us period during power-down", n, 3);
    pdown = 1'b0;
    settled_period(4, n); chk("R6 mod period after wake", n, 64);

    // R10/R11: flags
    usec_div = 8'd1; msec_div = 16'd1; irq_en = 2'b01;
    wait_tick(1); wait_tick(1);
    @(negedge clk);
    chk("R10 ms flag set", int'(irq_flag[0]), 1);
    chk("R11 ms irq raised", int'(irq[0]), 1);
    wait_tick(1);
    @(negedge clk);
    irq_clr = 2'b01;
    @(negedge clk);
    irq_clr = 2'b00;
    chk("R10 ms flag cleared", int'(irq_flag[0]), 0);
    wait_tick(1);
    irq_clr = 2'b01;
    @(negedge clk);
    irq_clr = 2'b00;
    chk("R10 set wins over clear", int'(irq_flag[0]), 1);
    irq_en = 2'b00;
    @(negedge clk);
    chk("R11 masked irq low", int'(irq[0]), 0);
    chk("R10 flag held while masked", int'(irq_flag[0]), 1);
    irq_en = 2'b10;
    wait_tick(3);
    @(negedge clk);
    chk("R10 sec flag set", int'(irq_flag[1]), 1);
    chk("R11 sec irq raised", int'(irq[1]), 1);

    finish_run();
  end
endmodule